// File: doc/BRIEF.md
# Alarm Interrupt Output Controller

This block owns one shared, active-low output line that carries either a free-running square wave or a level interrupt built from a set of alarms. An external comparator delivers one match pulse per alarm. Each pulse latches a sticky flag, and software clears that flag later with a per-alarm clear strobe. The flags latch in either output mode and with any enable setting, so software can poll them even when they do not reach the pin.

A small configuration register holds the output mode and one interrupt-enable bit per alarm. It is loaded with a write strobe. In square-wave mode the line follows the prescaler's square wave and no alarm reaches it. In interrupt mode the line is pulled low for as long as any enabled flag is set. The line is registered. Every input's effect appears on the outputs after the next rising clock edge, which gives the pin a single, uniform latency of one cycle.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: During and after reset, all flags read 0, the output line is released (1), the mode is square wave, and every enable bit is 0.
- R2: A 1 on bit i of `match_i` sets flag i, and the flag is visible on `flags_o[i]` after the next rising edge. This happens in both modes and with any enable setting.
- R3: A set flag stays set until a 1 on its bit of `clr_i`, and then it reads 0 after the next rising edge.
- R4: When a match and a clear for the same alarm fall in the same cycle, that flag is 1 afterwards.
- R5: In square-wave mode (mode bit 0), `out_n_o` equals the value `sqw_i` had one cycle earlier. Flags and enables do not affect the line in this mode.
- R6: In interrupt mode (mode bit 1), `out_n_o` is 0 exactly when some alarm i has both flag i and enable bit i set. A flag whose enable bit is 0 never pulls the line low.
- R7: The interrupt is a level. It stays low while an enabled flag remains set, and it is released in the cycle after the last enabled flag is cleared.
- R8: Mode and enables are loaded from `cfg_mode_i` and `cfg_en_i` (bit i enables alarm i) when `cfg_we_i` is 1, and they act on the line after that edge. For example, enabling an alarm whose flag is already set pulls the line low on the next cycle. While `cfg_we_i` is 0 the configuration inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | NUM_ALARMS | Alarm match pulses, one bit per alarm |
| clr_i | input | NUM_ALARMS | Flag clear strobes, one bit per alarm |
| sqw_i | input | 1 | Square wave from the prescaler |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 1 | Mode to load: 0 square wave, 1 interrupt |
| cfg_en_i | input | NUM_ALARMS | Interrupt enables to load, bit i for alarm i |
| flags_o | output | NUM_ALARMS | Sticky alarm flags |
| out_n_o | output | 1 | Shared line level: 0 pulled low, 1 released |

## Verification
The bench sweeps every combination of mode, enable pair, prior flag pair, match pair, clear pair and square-wave level. This covers the case where a match and a clear arrive together: a design that favoured the clear would drop an alarm that is still pending. It also covers the case of a flag that is set but not enabled: a design that skipped the enable gating would raise spurious interrupts. Directed sequences go after release timing and late enabling. They check that the line is released one cycle after the last enabled flag clears, and not while a second flag is still pending. They check that an enable written onto an already-set flag pulls the line low on the next cycle, and that configuration data presented without a write strobe changes nothing. A square-wave run checks that alarms never leak onto the line in that mode.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  typedef enum logic {
    PIN_SQW = 1'b0,
    PIN_IRQ = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/alarm_cfg_reg.sv
module alarm_cfg_reg
  import alarm_irq_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  mode_i,
  input  logic [NUM_ALARMS-1:0] en_i,
  output pin_mode_e             mode_q_o,
  output logic [NUM_ALARMS-1:0] en_q_o,
  output pin_mode_e             mode_d_o,
  output logic [NUM_ALARMS-1:0] en_d_o
);
  assign mode_d_o = we_i ? pin_mode_e'(mode_i) : mode_q_o;
  assign en_d_o   = we_i ? en_i : en_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= PIN_SQW;
      en_q_o   <= '0;
    end else begin
      mode_q_o <= mode_d_o;
      en_q_o   <= en_d_o;
    end
  end
endmodule

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic [NUM_ALARMS-1:0] clr_i,
  output logic [NUM_ALARMS-1:0] flag_q_o,
  output logic [NUM_ALARMS-1:0] flag_d_o
);
  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_flag
    logic q;
    // match wins over a same-cycle clear
    assign flag_d_o[g] = match_i[g] | (q & ~clr_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= flag_d_o[g];
    end
    assign flag_q_o[g] = q;
  end
endmodule

// File: rtl/alarm_pin_drv.sv
module alarm_pin_drv
  import alarm_irq_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  pin_mode_e             mode_d_i,
  input  logic [NUM_ALARMS-1:0] en_d_i,
  input  logic [NUM_ALARMS-1:0] flag_d_i,
  input  logic                  sqw_i,
  output logic                  out_n_o
);
  logic irq_req;
  logic pull_low;

  assign irq_req  = |(flag_d_i & en_d_i);
  assign pull_low = (mode_d_i == PIN_IRQ) ? irq_req : ~sqw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_n_o <= 1'b1;
    else         out_n_o <= ~pull_low;
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_ALARMS-1:0] match_i,
  input  logic [NUM_ALARMS-1:0] clr_i,
  input  logic                  sqw_i,
  input  logic                  cfg_we_i,
  input  logic                  cfg_mode_i,
  input  logic [NUM_ALARMS-1:0] cfg_en_i,
  output logic [NUM_ALARMS-1:0] flags_o,
  output logic                  out_n_o
);
  pin_mode_e             mode_q, mode_d;
  logic [NUM_ALARMS-1:0] en_q, en_d;
  logic [NUM_ALARMS-1:0] flag_d;

  alarm_cfg_reg #(.NUM_ALARMS(NUM_ALARMS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .mode_i   (cfg_mode_i),
    .en_i     (cfg_en_i),
    .mode_q_o (mode_q),
    .en_q_o   (en_q),
    .mode_d_o (mode_d),
    .en_d_o   (en_d)
  );

  alarm_flag_bank #(.NUM_ALARMS(NUM_ALARMS)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .match_i  (match_i),
    .clr_i    (clr_i),
    .flag_q_o (flags_o),
    .flag_d_o (flag_d)
  );

  alarm_pin_drv #(.NUM_ALARMS(NUM_ALARMS)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_d_i (mode_d),
    .en_d_i   (en_d),
    .flag_d_i (flag_d),
    .sqw_i    (sqw_i),
    .out_n_o  (out_n_o)
  );
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_ALARMS-1:0] match_i,
  input logic [NUM_ALARMS-1:0] clr_i,
  input logic                  sqw_i,
  input logic                  cfg_we_i,
  input logic [NUM_ALARMS-1:0] flags_o,
  input logic                  out_n_o,
  input logic                  mode_q,
  input logic [NUM_ALARMS-1:0] en_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == '0 && out_n_o && !mode_q && en_q == '0));

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_bit
    // R2
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[g] |=> flags_o[g]);
    // R3
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[g] && !clr_i[g]) |=> flags_o[g]);
    // R3
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !match_i[g]) |=> !flags_o[g]);
    // R4
    match_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && match_i[g]) |=> flags_o[g]);
  end

  // R5
  sqw_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !mode_q) |-> (out_n_o == $past(sqw_i)));

  // R6
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> (out_n_o == !(|(flags_o & en_q))));

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(en_q) && $stable(mode_q)));
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .match_i  (match_i),
  .clr_i    (clr_i),
  .sqw_i    (sqw_i),
  .cfg_we_i (cfg_we_i),
  .flags_o  (flags_o),
  .out_n_o  (out_n_o),
  .mode_q   (mode_q),
  .en_q     (en_q)
);

// File: tb/alarm_irq_ctrl_tb.sv
module alarm_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [NA-1:0] match_i = '0;
  logic [NA-1:0] clr_i = '0;
  logic          sqw_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic          cfg_mode_i = 1'b0;
  logic [NA-1:0] cfg_en_i = '0;
  logic [NA-1:0] flags_o;
  logic          out_n_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alarm_irq_ctrl #(.NUM_ALARMS(NA)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match_i), .clr_i(clr_i),
    .sqw_i(sqw_i), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_en_i(cfg_en_i), .flags_o(flags_o), .out_n_o(out_n_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    match_i = '0; clr_i = '0; cfg_we_i = 1'b0; cfg_en_i = '0; cfg_mode_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R1 flags in reset", int'(flags_o), 0);
    check("R1 line in reset", int'(out_n_o), 1);
    rst_ni = 1'b1;

    // R1 defaults: square mode, enables off
    match_i = 2'b11; sqw_i = 1'b1;
    @(negedge clk_i);
    match_i = '0;
    check("R2 flags after match", int'(flags_o), 3);
    check("R1 default enables off", int'(out_n_o), 1);
    sqw_i = 1'b0;
    @(negedge clk_i);
    check("R1 default square mode", int'(out_n_o), 0);

    // sweep: mode, enables, prior flags, match, clear, sqw
    for (int md = 0; md < 2; md++)
      for (int en = 0; en < 4; en++)
        for (int pf = 0; pf < 4; pf++)
          for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
              for (int s = 0; s < 2; s++) begin
                int ef, ep;
                do_reset();
                cfg_we_i = 1'b1; cfg_mode_i = md[0]; cfg_en_i = en[1:0];
                match_i = pf[1:0]; sqw_i = 1'b0;
                @(negedge clk_i);
                cfg_we_i = 1'b0; match_i = m[1:0]; clr_i = c[1:0]; sqw_i = s[0];
                @(negedge clk_i);
                ef = (pf & ~c & 3) | m;
                ep = md ? ((ef & en) != 0 ? 0 : 1) : s;
                check("R2 R3 R4 sweep flags", int'(flags_o), ef);
                check(md ? "R6 sweep line" : "R5 sweep line", int'(out_n_o), ep);
                match_i = '0; clr_i = '0;
              end

    // late enable and level release
    do_reset();
    cfg_we_i = 1'b1; cfg_mode_i = 1'b1; cfg_en_i = 2'b00; match_i = 2'b01;
    @(negedge clk_i);
    cfg_we_i = 1'b0; match_i = '0;
    check("R6 disabled flag keeps line released", int'(out_n_o), 1);
    cfg_we_i = 1'b1; cfg_en_i = 2'b01;
    @(negedge clk_i);
    check("R8 enable onto set flag", int'(out_n_o), 0);
    cfg_we_i = 1'b0; cfg_en_i = 2'b00; cfg_mode_i = 1'b0;
    @(negedge clk_i);
    check("R8 config ignored without strobe", int'(out_n_o), 0);
    check("R7 level held", int'(out_n_o), 0);
    clr_i = 2'b01;
    @(negedge clk_i);
    clr_i = '0;
    check("R7 release after clear", int'(out_n_o), 1);
    check("R3 flag cleared", int'(flags_o), 0);

    cfg_we_i = 1'b1; cfg_mode_i = 1'b1; cfg_en_i = 2'b11; match_i = 2'b11;
    @(negedge clk_i);
    cfg_we_i = 1'b0; match_i = '0; clr_i = 2'b01;
    @(negedge clk_i);
    check("R7 held while second flag set", int'(out_n_o), 0);
    clr_i = 2'b10;
    @(negedge clk_i);
    clr_i = '0;
    check("R7 release after last flag", int'(out_n_o), 1);
    @(negedge clk_i);
    check("R7 stays released", int'(out_n_o), 1);

    // square wave with pending enabled alarms
    do_reset();
    cfg_we_i = 1'b1; cfg_mode_i = 1'b0; cfg_en_i = 2'b11; match_i = 2'b11;
    @(negedge clk_i);
    cfg_we_i = 1'b0; match_i = '0;
    for (int k = 0; k < 12; k++) begin
      logic v;
      v = k[0] ^ k[2];
      sqw_i = v;
      @(negedge clk_i);
      check("R5 square wave follows input", int'(out_n_o), int'(v));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule